// File: doc/BRIEF.md
# Fetch Operation Sampler

The sampler sits beside a front-end fetch pipeline and picks one fetch operation out of every programmable number of them for detailed profiling. Each fetch operation advances a period counter. A fetch operation is either a sequential 32-byte block or a fetch that starts at a redirection target. When the counter reaches the programmed period, the fetch that reaches it is tagged. The sampler stores the address of that fetch exactly as issued, which may be a block start inside an instruction. It also records whether the fetch began at a redirection.

A cycle timer starts when the fetch is tagged. When the completion strobe arrives, the sampler stores the latency, which saturates. At the same point it stores the completion flags: a cache-miss flag and a flag for bytes that a late redirect discarded. The sample is still reported when the bytes were discarded. The valid bit and the interrupt then stay high and the counter is frozen until software clears the valid bit. Software reaches the control, period, count and sample fields through a simple select-based write port and a combinational read port.

Top module: `fetch_sampler`

## Requirements
- R1: After reset the enable bit, valid bit, period, count, captured address and sample info all read 0, and irq_o is low.
- R2: When enable is set and no sample is in flight or pending, each cycle with fetch_vld_i high adds one to the count. With enable clear, fetches leave the count unchanged.
- R3: A fetch whose count plus one is at least the period is tagged and returns the count to 0. A period of P≥1 therefore tags every P-th fetch, and a period of 0 tags every fetch.
- R4: The ADDR field (select 3) holds fetch_addr_i of the tagged fetch unchanged, with no alignment applied.
- R5: The latency is the number of clock edges from the edge that tags the fetch to the edge that samples cmpl_vld_i high. A completion on the very next edge gives 1.
- R6: The latency saturates at 2^LAT_W−1 and does not wrap.
- R7: INFO (select 4) holds the latency in bits [LAT_W-1:0]. It holds the completion miss flag at bit LAT_W, the tagged fetch's fetch_redir_i at bit LAT_W+1 and the completion drop flag at bit LAT_W+2. A sample with the drop flag set is still reported as valid.
- R8: While a tagged fetch is waiting for completion or a sample is pending, fetches neither advance the count nor tag anything.
- R9: A write to CTRL (select 0) with bit 1 = 0 clears valid. Writing bit 1 = 1 leaves valid unchanged. Bit 0 of the same write sets enable.
- R10: PERIOD (select 1) and COUNT (select 2) are writable. A COUNT write wins over an increment in the same cycle.
- R11: irq_o is high exactly while the valid bit (CTRL bit 1) reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_vld_i | input | 1 | One fetch operation issued this cycle |
| fetch_addr_i | input | ADDR_W | Address of the issued fetch |
| fetch_redir_i | input | 1 | Issued fetch starts at a redirection target |
| cmpl_vld_i | input | 1 | Tagged fetch completes this cycle |
| cmpl_miss_i | input | 1 | Completing fetch missed the instruction cache |
| cmpl_drop_i | input | 1 | Completing fetch's bytes were discarded by a late redirect |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for writes |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 3 | Register select for reads |
| rd_data_o | output | DATA_W | Read data, combinational from rd_sel_i |
| irq_o | output | 1 | Sample pending |

## Verification
Every state change lands on the clock edge that samples the causing strobe. The count, valid bit, captured fields and irq_o are therefore readable from the cycle after that edge, and the read port adds no delay. The bench drives inputs and samples outputs 1 ns after a rising edge. It reads each field only after the edge that should have updated it. It places the completion strobe exactly d edges after the tagging edge, so the expected latency is min(d, 2^LAT_W−1). It sweeps every period from 0 to 5 against several latencies, with fetches held active while a tag is in flight.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_PERIOD = 3'd1;
  localparam logic [2:0] SEL_COUNT  = 3'd2;
  localparam logic [2:0] SEL_ADDR   = 3'd3;
  localparam logic [2:0] SEL_INFO   = 3'd4;

  typedef struct packed {
    logic drop;
    logic redir;
    logic miss;
  } flags_t;
endpackage

// File: rtl/fs_period_ctr.sv
module fs_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tag_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] count_q;
  logic [EXT_W-1:0] count_inc;
  logic             hit;

  assign count_inc = {1'b0, count_q} + EXT_W'(1);
  assign hit       = count_inc >= {1'b0, period_i};
  assign tag_o     = fire_i & hit;
  assign count_o   = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (cnt_we_i) count_q <= cnt_wd_i;
    else if (fire_i)   count_q <= hit ? '0 : count_inc[CNT_W-1:0];
  end

  a_r3_tag_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o && !cnt_we_i |=> count_q == '0);
endmodule

// File: rtl/fs_lat_timer.sv
module fs_lat_timer #(
  parameter int LAT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tag_i,
  input  logic             cmpl_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [LAT_W-1:0] lat_done_o
);
  localparam logic [LAT_W-1:0] LAT_MAX = '1;

  logic             busy_q;
  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] lat_inc;

  assign lat_inc    = (lat_q == LAT_MAX) ? LAT_MAX : lat_q + LAT_W'(1);
  assign busy_o     = busy_q;
  assign done_o     = busy_q & cmpl_i;
  assign lat_done_o = lat_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
    end else if (tag_i) begin
      busy_q <= 1'b1;
      lat_q  <= '0;
    end else if (busy_q && cmpl_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      lat_q <= lat_inc;
    end
  end

  a_r5_tag_starts_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_i |=> busy_q && lat_q == '0);
  a_r6_lat_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !cmpl_i && !tag_i && lat_q == LAT_MAX |=> lat_q == LAT_MAX);
endmodule

// File: rtl/fs_record.sv
module fs_record #(
  parameter int ADDR_W = 32,
  parameter int LAT_W  = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tag_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                redir_i,
  input  logic                done_i,
  input  logic [LAT_W-1:0]    lat_i,
  input  logic                miss_i,
  input  logic                drop_i,
  input  logic                clr_i,
  output logic                valid_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [LAT_W-1:0]    lat_o,
  output fs_pkg::flags_t      flags_o
);
  logic               valid_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LAT_W-1:0]   lat_q;
  fs_pkg::flags_t     flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      lat_q   <= '0;
      flags_q <= '0;
    end else begin
      if (tag_i) begin
        addr_q        <= addr_i;
        flags_q.redir <= redir_i;
      end
      if (done_i) begin
        lat_q        <= lat_i;
        flags_q.miss <= miss_i;
        flags_q.drop <= drop_i;
        valid_q      <= 1'b1;
      end else if (clr_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign lat_o   = lat_q;
  assign flags_o = flags_q;

  a_r7_valid_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(done_i));
  a_r4_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !tag_i |=> $stable(addr_q));
endmodule

// File: rtl/fetch_sampler.sv
module fetch_sampler #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LAT_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_vld_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_redir_i,
  input  logic              cmpl_vld_i,
  input  logic              cmpl_miss_i,
  input  logic              cmpl_drop_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  import fs_pkg::*;

  localparam int INFO_W = LAT_W + 3;

  logic              enable_q;
  logic [CNT_W-1:0]  period_q;
  logic [CNT_W-1:0]  count;
  logic              fire, tag, busy, done, valid, clr, cnt_we;
  logic [LAT_W-1:0]  lat_done, lat_rec;
  logic [ADDR_W-1:0] addr_rec;
  flags_t            flags_rec;
  logic              unused_wdata;

  assign unused_wdata = ^wr_data_i;
  assign fire   = fetch_vld_i & enable_q & ~busy & ~valid;
  assign cnt_we = wr_en_i && wr_sel_i == SEL_COUNT;
  assign clr    = wr_en_i && wr_sel_i == SEL_CTRL && !wr_data_i[1];
  assign irq_o  = valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      period_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_CTRL)   enable_q <= wr_data_i[0];
      if (wr_sel_i == SEL_PERIOD) period_q <= wr_data_i[CNT_W-1:0];
    end
  end

  fs_period_ctr #(.CNT_W(CNT_W)) i_period_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .period_i (period_q),
    .cnt_we_i (cnt_we),
    .cnt_wd_i (wr_data_i[CNT_W-1:0]),
    .count_o  (count),
    .tag_o    (tag)
  );

  fs_lat_timer #(.LAT_W(LAT_W)) i_lat_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tag_i      (tag),
    .cmpl_i     (cmpl_vld_i),
    .busy_o     (busy),
    .done_o     (done),
    .lat_done_o (lat_done)
  );

  fs_record #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) i_record (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tag_i   (tag),
    .addr_i  (fetch_addr_i),
    .redir_i (fetch_redir_i),
    .done_i  (done),
    .lat_i   (lat_done),
    .miss_i  (cmpl_miss_i),
    .drop_i  (cmpl_drop_i),
    .clr_i   (clr),
    .valid_o (valid),
    .addr_o  (addr_rec),
    .lat_o   (lat_rec),
    .flags_o (flags_rec)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_sel_i)
      SEL_CTRL:   rd_data_o[1:0]          = {valid, enable_q};
      SEL_PERIOD: rd_data_o[CNT_W-1:0]    = period_q;
      SEL_COUNT:  rd_data_o[CNT_W-1:0]    = count;
      SEL_ADDR:   rd_data_o[ADDR_W-1:0]   = addr_rec;
      SEL_INFO:   rd_data_o[INFO_W-1:0]   = {flags_rec, lat_rec};
      default:    rd_data_o               = '0;
    endcase
  end

  a_r8_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid || busy) && !cnt_we |=> $stable(count));
  a_r8_no_tag_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid || busy |-> !tag);
  a_r7_busy_valid_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && valid));
  a_r11_irq_rise_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cmpl_vld_i));
endmodule

// File: tb/test_fetch_sampler.sv
module test_fetch_sampler;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 4;
  localparam int LAT_W  = 4;
  localparam int DATA_W = 16;
  localparam int LMAX   = (1 << LAT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fetch_vld = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic              fetch_redir = 1'b0;
  logic              cmpl_vld = 1'b0, cmpl_miss = 1'b0, cmpl_drop = 1'b0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_sel = '0, rd_sel = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fetch_sampler #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LAT_W(LAT_W), .DATA_W(DATA_W)) i_fetch_sampler (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_vld_i(fetch_vld), .fetch_addr_i(fetch_addr), .fetch_redir_i(fetch_redir),
    .cmpl_vld_i(cmpl_vld), .cmpl_miss_i(cmpl_miss), .cmpl_drop_i(cmpl_drop),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, output int val);
    rd_sel = sel;
    #1;
    val = int'(rd_data);
  endtask

  task automatic wr(input logic [2:0] sel, input int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = DATA_W'(val);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic fetch(input int addr, input logic redir);
    fetch_vld = 1'b1; fetch_addr = ADDR_W'(addr); fetch_redir = redir;
    @(posedge clk); #1;
    fetch_vld = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v); check("R1 reset field", v, 0);
    end
    check("R1 irq reset", int'(irq), 0);

    // R2 disabled: no counting
    wr(3'd1, 4);
    fetch(12, 1'b0); fetch(13, 1'b0); fetch(14, 1'b0);
    rd(3'd2, v); check("R2 disabled count", v, 0);

    // R10 count write overrides increment
    wr(3'd1, 8); wr(3'd0, 1);
    fetch_vld = 1'b1;
    wr(3'd2, 5);
    fetch_vld = 1'b0;
    rd(3'd2, v); check("R10 write wins", v, 5);
    rd(3'd1, v); check("R10 period readback", v, 8);
    fetch(1, 1'b0);
    rd(3'd2, v); check("R2 increment", v, 6);
    wr(3'd0, 0);
    fetch(1, 1'b0);
    rd(3'd2, v); check("R2 gated by enable", v, 6);

    // Sweep of period and latency
    for (int p = 0; p <= 5; p++) begin
      for (int k = 0; k < 4; k++) begin
        int d, eff, taddr, exp_info;
        logic tredir, miss, drop;
        d = (k == 3) ? 17 : k + 1;
        eff = (p == 0) ? 1 : p;
        miss = d[0]; drop = p[0];
        wr(3'd1, p); wr(3'd2, 0); wr(3'd0, 1);
        taddr = 0; tredir = 1'b0;
        for (int i = 1; i <= eff; i++) begin
          int a;
          a = (p * 37 + i * 5 + k * 3 + 1) & 12'hfff;
          fetch(a, i[0]);
          taddr = a; tredir = i[0];
          rd(3'd2, v);
          if (i < eff) check("R2 count step", v, i);
          else         check("R3 tag clears count", v, 0);
          check("R3 no irq before completion", int'(irq), 0);
        end
        // fetches in flight, R8
        if (d > 1) begin
          fetch_vld = 1'b1; fetch_addr = 12'habc; fetch_redir = ~tredir;
          repeat (d - 1) @(posedge clk);
          #1 fetch_vld = 1'b0;
        end
        rd(3'd2, v); check("R8 frozen in flight", v, 0);
        cmpl_vld = 1'b1; cmpl_miss = miss; cmpl_drop = drop;
        @(posedge clk); #1;
        cmpl_vld = 1'b0;
        check("R11 irq on sample", int'(irq), 1);
        rd(3'd0, v); check("R11 valid bit", v, 3);
        rd(3'd3, v); check("R4 tagged addr", v, taddr);
        exp_info = (d > LMAX ? LMAX : d) | (int'(miss) << LAT_W)
                 | (int'(tredir) << (LAT_W + 1)) | (int'(drop) << (LAT_W + 2));
        rd(3'd4, v);
        if (d > LMAX) check("R6 saturated info", v, exp_info);
        else          check("R5 R7 info", v, exp_info);
        fetch(77, 1'b1); fetch(78, 1'b0);
        rd(3'd2, v); check("R8 frozen pending", v, 0);
        rd(3'd3, v); check("R8 addr held", v, taddr);
        wr(3'd0, 3);
        check("R9 set bit ignored", int'(irq), 1);
        wr(3'd0, 1);
        check("R9 clear", int'(irq), 0);
        rd(3'd0, v); check("R9 ctrl after clear", v, 1);
      end
    end
    finish_run();
  end
endmodule